// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs exception entry and return for a simple in-order processor. Each cycle it samples eight synchronous instruction-exception request lines, three hardware-error lines, a timer request and six external interrupt lines. It also samples the address of the instruction in flight and the address of the instruction after it. When a request is accepted, the block saves a return address and records an exception code. It forces the processor into kernel mode and issues a one-cycle redirect to the handler entry address for that class of exception.

A return-from-exception pulse sends the program counter back to the saved return address and puts the processor back in user mode. The cause register also carries a pending mask, which copies the external interrupt lines in every cycle so that a handler can see which lines are raised. All outputs are registered. A request sampled at one clock edge is visible on the outputs just after that edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low, kernel_mode is 1 and the following are all zero: epc, cause_code, cause_pend and redir_valid.
- R2: In the first clock after rst_n goes high, redir_valid pulses for one cycle with redir_pc = FFFF_FFFF_BFC0_0000, kernel_mode 1 and cause_code 0. No request is taken in that cycle.
- R3: The entry address depends on the class of the accepted exception. Hardware errors go to FFFF_FFFF_BFC0_0300 and external interrupts go to FFFF_FFFF_BFC0_0380. Synchronous exceptions and the timer go to FFFF_FFFF_BFC0_0400.
- R4: An accepted request gives redir_valid = 1 and kernel_mode = 1 on the edge that samples it. redir_valid is 0 in every cycle with no accepted request and no return.
- R5: The saved return address epc is cur_pc for hardware errors and for sync_req bits 0, 1, 2, 6 and 7. These bits are address error, reserved instruction, TLB miss, overflow and floating-point error. epc is next_pc for sync_req bits 3, 4 and 5 (system call, breakpoint, trap), for the timer and for external interrupts.
- R6: cause_code is written on entry. The code is 0 for reset and 1+i for hw_err bit i (machine check, bus error, cache error). It is 4+i for sync_req bit i, 12 for the timer and 16+i for ext_irq bit i.
- R7: The timer and external interrupts are accepted only when int_en is 1 and kernel_mode is 0. Otherwise they produce no redirect and leave epc, cause_code and kernel_mode unchanged. Synchronous exceptions and hardware errors are accepted in either mode.
- R8: When eret is pulsed and no exception is accepted in that cycle, redir_valid pulses with redir_pc equal to epc, and kernel_mode becomes 0.
- R9: Simultaneous requests are taken in a fixed order. Hardware errors come first, then synchronous exceptions, then the timer, then external interrupts. Within a group, the lowest bit index wins.
- R10: cause_pend shows ext_irq as sampled at the previous clock edge, in every cycle after reset, whether or not an interrupt is accepted.
- R11: If an exception is accepted in the same cycle as eret, the exception is taken, kernel_mode stays 1 and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_req | input | 8 | Synchronous exception requests, bit order as in R5/R6 |
| hw_err | input | 3 | Hardware error requests: machine check, bus error, cache error |
| timer_req | input | 1 | Timer interrupt request |
| ext_irq | input | 6 | External interrupt request lines |
| int_en | input | 1 | Global interrupt enable |
| eret | input | 1 | Return-from-exception pulse |
| cur_pc | input | 64 | Address of the instruction in flight |
| next_pc | input | 64 | Address of the following instruction |
| redir_valid | output | 1 | One-cycle program counter redirect strobe |
| redir_pc | output | 64 | Redirect target address |
| epc | output | 64 | Saved return address |
| cause_code | output | 5 | Exception code of the last entry |
| cause_pend | output | 6 | Sampled external interrupt lines |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode |

## Verification
The case that needs the most care is an exception entry and a return from exception falling in the same cycle. The bench forces it by raising an overflow request together with eret while the block is in kernel mode. It then expects a redirect to the general vector with epc taken from cur_pc and kernel mode held, not a return to the old epc. A second collision is the timer and an external interrupt raised together in user mode. For that case the bench expects code 12 at the general vector, with the pending mask still showing the interrupt line.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam logic [63:0] VA_BOOT = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [63:0] VA_HW   = 64'hFFFF_FFFF_BFC0_0300;
    localparam logic [63:0] VA_IRQ  = 64'hFFFF_FFFF_BFC0_0380;
    localparam logic [63:0] VA_GEN  = 64'hFFFF_FFFF_BFC0_0400;

    // exception code bases
    localparam logic [4:0] EC_RESET = 5'd0;
    localparam logic [4:0] EC_HW0   = 5'd1;
    localparam logic [4:0] EC_SYNC0 = 5'd4;
    localparam logic [4:0] EC_TIMER = 5'd12;
    localparam logic [4:0] EC_IRQ0  = 5'd16;

    typedef enum logic [1:0] {
        VS_BOOT,
        VS_HW,
        VS_IRQ,
        VS_GEN
    } vec_sel_e;

    typedef struct packed {
        logic       take;
        logic [4:0] code;
        logic       use_next;
        vec_sel_e   vsel;
    } exc_win_t;

    function automatic logic [63:0] vec_addr(input vec_sel_e s);
        case (s)
            VS_BOOT: vec_addr = VA_BOOT;
            VS_HW:   vec_addr = VA_HW;
            VS_IRQ:  vec_addr = VA_IRQ;
            default: vec_addr = VA_GEN;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // lowest set index wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int              N_SYNC    = 8,
    parameter int              N_HW      = 3,
    parameter int              N_IRQ     = 6,
    parameter logic [N_SYNC-1:0] SYNC_NEXT = 8'b0011_1000
) (
    input  logic [N_SYNC-1:0] sync_req,
    input  logic [N_HW-1:0]   hw_err,
    input  logic              timer_req,
    input  logic [N_IRQ-1:0]  ext_irq,
    input  logic              irq_ok,
    output exc_win_t          win
);
    localparam int SW = (N_SYNC > 1) ? $clog2(N_SYNC) : 1;
    localparam int HW = (N_HW   > 1) ? $clog2(N_HW)   : 1;
    localparam int IW = (N_IRQ  > 1) ? $clog2(N_IRQ)  : 1;

    logic          sync_any, hw_any, irq_any;
    logic [SW-1:0] sync_idx;
    logic [HW-1:0] hw_idx;
    logic [IW-1:0] irq_idx;

    exc_prio_pick #(.N(N_SYNC)) u_sync (.req(sync_req), .any(sync_any), .idx(sync_idx));
    exc_prio_pick #(.N(N_HW))   u_hw   (.req(hw_err),   .any(hw_any),   .idx(hw_idx));
    exc_prio_pick #(.N(N_IRQ))  u_irq  (.req(ext_irq),  .any(irq_any),  .idx(irq_idx));

    always_comb begin
        win = '{take: 1'b0, code: EC_RESET, use_next: 1'b0, vsel: VS_GEN};
        if (hw_any) begin
            win.take     = 1'b1;
            win.code     = EC_HW0 + 5'(hw_idx);
            win.use_next = 1'b0;
            win.vsel     = VS_HW;
        end else if (sync_any) begin
            win.take     = 1'b1;
            win.code     = EC_SYNC0 + 5'(sync_idx);
            win.use_next = SYNC_NEXT[sync_idx];
            win.vsel     = VS_GEN;
        end else if (irq_ok && timer_req) begin
            win.take     = 1'b1;
            win.code     = EC_TIMER;
            win.use_next = 1'b1;
            win.vsel     = VS_GEN;
        end else if (irq_ok && irq_any) begin
            win.take     = 1'b1;
            win.code     = EC_IRQ0 + 5'(irq_idx);
            win.use_next = 1'b1;
            win.vsel     = VS_IRQ;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int N_SYNC = 8,
    parameter int N_HW   = 3,
    parameter int N_IRQ  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SYNC-1:0] sync_req,
    input  logic [N_HW-1:0]   hw_err,
    input  logic              timer_req,
    input  logic [N_IRQ-1:0]  ext_irq,
    input  logic              int_en,
    input  logic              eret,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   next_pc,
    output logic              redir_valid,
    output logic [PC_W-1:0]   redir_pc,
    output logic [PC_W-1:0]   epc,
    output logic [4:0]        cause_code,
    output logic [N_IRQ-1:0]  cause_pend,
    output logic              kernel_mode
);
    typedef struct packed {
        logic             boot;
        logic             kernel;
        logic [PC_W-1:0]  epc;
        logic [4:0]       code;
        logic [N_IRQ-1:0] pend;
        logic             rv;
        logic [PC_W-1:0]  rpc;
    } st_t;

    st_t      st_d, st_q;
    exc_win_t win;
    logic     irq_ok;
    logic [63:0] vec_full;

    assign irq_ok = int_en & ~st_q.kernel;

    exc_arbiter #(
        .N_SYNC(N_SYNC),
        .N_HW  (N_HW),
        .N_IRQ (N_IRQ)
    ) u_arb (
        .sync_req (sync_req),
        .hw_err   (hw_err),
        .timer_req(timer_req),
        .ext_irq  (ext_irq),
        .irq_ok   (irq_ok),
        .win      (win)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.pend = ext_irq;
        vec_full  = vec_addr(st_q.boot ? VS_BOOT : win.vsel);
        if (st_q.boot) begin
            st_d.boot   = 1'b0;
            st_d.rv     = 1'b1;
            st_d.rpc    = vec_full[PC_W-1:0];
            st_d.kernel = 1'b1;
            st_d.code   = EC_RESET;
        end else if (win.take) begin
            st_d.rv     = 1'b1;
            st_d.rpc    = vec_full[PC_W-1:0];
            st_d.kernel = 1'b1;
            st_d.code   = win.code;
            st_d.epc    = win.use_next ? next_pc : cur_pc;
        end else if (eret) begin
            st_d.rv     = 1'b1;
            st_d.rpc    = st_q.epc;
            st_d.kernel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.boot   <= 1'b1;
            st_q.kernel <= 1'b1;
            st_q.epc    <= '0;
            st_q.code   <= '0;
            st_q.pend   <= '0;
            st_q.rv     <= 1'b0;
            st_q.rpc    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_valid = st_q.rv;
    assign redir_pc    = st_q.rpc;
    assign epc         = st_q.epc;
    assign cause_code  = st_q.code;
    assign cause_pend  = st_q.pend;
    assign kernel_mode = st_q.kernel;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int N_SYNC = 8,
    parameter int N_HW   = 3,
    parameter int N_IRQ  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SYNC-1:0] sync_req,
    input logic [N_HW-1:0]   hw_err,
    input logic              timer_req,
    input logic [N_IRQ-1:0]  ext_irq,
    input logic              int_en,
    input logic              eret,
    input logic              redir_valid,
    input logic [PC_W-1:0]   redir_pc,
    input logic [PC_W-1:0]   epc,
    input logic [4:0]        cause_code,
    input logic [N_IRQ-1:0]  cause_pend,
    input logic              kernel_mode
);
    localparam logic [PC_W-1:0] P_BOOT = PC_W'(VA_BOOT);
    localparam logic [PC_W-1:0] P_HW   = PC_W'(VA_HW);
    localparam logic [PC_W-1:0] P_IRQ  = PC_W'(VA_IRQ);
    localparam logic [PC_W-1:0] P_GEN  = PC_W'(VA_GEN);

    logic started_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && (|sync_req) |=> redir_valid && kernel_mode && cause_code != 5'd0) // R4
        else $error("sync entry");

    AST_VEC_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid && kernel_mode |->
            (redir_pc == P_BOOT || redir_pc == P_HW || redir_pc == P_IRQ || redir_pc == P_GEN)) // R3
        else $error("vector");

    AST_ERET_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && eret && sync_req == '0 && hw_err == '0 && !timer_req && ext_irq == '0
        |=> redir_valid && !kernel_mode && redir_pc == $past(epc)) // R8
        else $error("eret");

    AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |=> cause_pend == $past(ext_irq)) // R10
        else $error("pend");

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && !int_en && sync_req == '0 && hw_err == '0 && !eret |=> !redir_valid) // R7
        else $error("masked");

    AST_HW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && (|hw_err) |=> redir_pc == P_HW && cause_code >= 5'd1 && cause_code <= 5'd3) // R9
        else $error("hw prio");
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .PC_W(PC_W), .N_SYNC(N_SYNC), .N_HW(N_HW), .N_IRQ(N_IRQ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .hw_err(hw_err),
    .timer_req(timer_req), .ext_irq(ext_irq), .int_en(int_en), .eret(eret),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .epc(epc),
    .cause_code(cause_code), .cause_pend(cause_pend), .kernel_mode(kernel_mode)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sync_req = '0;
    logic [2:0]  hw_err = '0;
    logic        timer_req = 1'b0;
    logic [5:0]  ext_irq = '0;
    logic        int_en = 1'b0;
    logic        eret = 1'b0;
    logic [63:0] cur_pc = '0;
    logic [63:0] next_pc = '0;
    logic        redir_valid;
    logic [63:0] redir_pc;
    logic [63:0] epc;
    logic [4:0]  cause_code;
    logic [5:0]  cause_pend;
    logic        kernel_mode;

    always #(HALF) clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .hw_err(hw_err),
        .timer_req(timer_req), .ext_irq(ext_irq), .int_en(int_en), .eret(eret),
        .cur_pc(cur_pc), .next_pc(next_pc), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .epc(epc), .cause_code(cause_code),
        .cause_pend(cause_pend), .kernel_mode(kernel_mode)
    );

    typedef struct {
        string       req;
        logic        rv;
        logic [63:0] rpc;
        logic [63:0] epc;
        logic [4:0]  code;
        logic [5:0]  pend;
        logic        kern;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    bit          m_boot = 1;
    bit          m_kern = 1;
    logic [63:0] m_epc = '0;
    logic [4:0]  m_code = '0;
    int          n_step = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push its expected result
    task automatic step(input string req, input logic [7:0] s, input logic [2:0] h,
                        input logic t, input logic [5:0] x, input logic ie,
                        input logic er);
        item_t it;
        bit    taken = 0;
        logic [63:0] cp, np;
        @(negedge clk);
        cp = 64'h0000_0000_0040_0000 + 64'(n_step) * 64'h10;
        np = cp + 64'h4;
        n_step++;
        sync_req = s; hw_err = h; timer_req = t; ext_irq = x;
        int_en = ie; eret = er; cur_pc = cp; next_pc = np;
        rst_n = 1'b1;
        it.req = req; it.rv = 0; it.rpc = '0; it.pend = x;
        if (m_boot) begin
            m_boot = 0; it.rv = 1; it.rpc = 64'hFFFF_FFFF_BFC0_0000;
            m_kern = 1; m_code = 0;
        end else begin
            for (int i = 0; i < 3 && !taken; i++) if (h[i]) begin
                taken = 1; m_code = 5'(1 + i); m_epc = cp;
                it.rpc = 64'hFFFF_FFFF_BFC0_0300;
            end
            for (int i = 0; i < 8 && !taken; i++) if (s[i]) begin
                taken = 1; m_code = 5'(4 + i);
                m_epc = (i >= 3 && i <= 5) ? np : cp;
                it.rpc = 64'hFFFF_FFFF_BFC0_0400;
            end
            if (!taken && ie && !m_kern && t) begin
                taken = 1; m_code = 5'd12; m_epc = np;
                it.rpc = 64'hFFFF_FFFF_BFC0_0400;
            end
            for (int i = 0; i < 6 && !taken && ie && !m_kern; i++) if (x[i]) begin
                taken = 1; m_code = 5'(16 + i); m_epc = np;
                it.rpc = 64'hFFFF_FFFF_BFC0_0380;
            end
            if (taken) begin
                it.rv = 1; m_kern = 1;
            end else if (er) begin
                it.rv = 1; it.rpc = m_epc; m_kern = 0;
            end
        end
        it.epc = m_epc; it.code = m_code; it.kern = m_kern;
        q.push_back(it);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.req, "redir_valid", 64'(redir_valid), 64'(it.rv));
                if (it.rv) chk(it.req, "redir_pc", redir_pc, it.rpc);
                chk(it.req, "epc", epc, it.epc);
                chk(it.req, "cause_code", 64'(cause_code), 64'(it.code));
                chk("R10", "cause_pend", 64'(cause_pend), 64'(it.pend));
                chk(it.req, "kernel_mode", 64'(kernel_mode), 64'(it.kern));
            end
        end
    end

    initial begin
        #(HALF * 2 * 10000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "kernel_mode", 64'(kernel_mode), 64'd1);
        chk("R1", "epc", epc, 64'd0);
        chk("R1", "cause_code", 64'(cause_code), 64'd0);
        chk("R1", "cause_pend", 64'(cause_pend), 64'd0);
        chk("R1", "redir_valid", 64'(redir_valid), 64'd0);

        step("R2", 8'h00, 3'b000, 0, 6'b000000, 0, 0);   // boot redirect
        step("R4", 8'h00, 3'b000, 0, 6'b000000, 0, 0);   // idle
        step("R8", 8'h00, 3'b000, 0, 6'b000000, 0, 1);   // return to epc 0
        step("R6", 8'h00, 3'b000, 0, 6'b001000, 1, 0);   // irq 3 -> 19
        step("R7", 8'h00, 3'b000, 0, 6'b001000, 1, 0);   // kernel: ignored
        step("R8", 8'h00, 3'b000, 0, 6'b000000, 0, 1);
        step("R7", 8'h00, 3'b000, 0, 6'b000001, 0, 0);   // disabled: ignored
        step("R7", 8'h00, 3'b000, 1, 6'b000000, 0, 0);   // timer disabled
        step("R9", 8'h00, 3'b000, 0, 6'b010100, 1, 0);   // irq 2 over 4
        step("R8", 8'h00, 3'b000, 0, 6'b000000, 0, 1);
        step("R9", 8'h00, 3'b000, 1, 6'b000010, 1, 0);   // timer over irq
        step("R8", 8'h00, 3'b000, 0, 6'b000000, 0, 1);
        step("R5", 8'b0000_1001, 3'b000, 0, 6'b000000, 0, 0); // addr over syscall
        step("R5", 8'b0000_1000, 3'b000, 0, 6'b000000, 0, 0); // syscall in kernel
        step("R9", 8'b0000_0010, 3'b010, 0, 6'b000000, 0, 0); // bus err over ri
        step("R11", 8'b0100_0000, 3'b000, 0, 6'b000000, 0, 1); // ovf with eret
        step("R8", 8'h00, 3'b000, 0, 6'b000000, 0, 1);
        step("R5", 8'b0001_0000, 3'b000, 0, 6'b100000, 0, 0); // breakpoint
        step("R3", 8'h00, 3'b100, 0, 6'b000000, 0, 0);   // cache error
        step("R6", 8'b1000_0000, 3'b000, 0, 6'b000000, 0, 0); // fp error -> 11
        step("R4", 8'h00, 3'b000, 0, 6'b000000, 0, 0);

        @(negedge clk);
        sync_req = '0; hw_err = '0; eret = 0; ext_irq = '0; timer_req = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule